// File: doc/BRIEF.md
# Modem Status Tracker

This block watches the four modem handshake lines of a 16550-style serial port and turns them into the read-only modem status byte and the modem-status interrupt request. The four external lines are active low. Each one passes through a two-flop synchronizer. The upper nibble of the status byte then shows each line as a positive "asserted" level. The lower nibble holds four sticky event flags. Three of them record any change of carrier detect, data set ready and clear to send. The fourth records only the trailing edge of the ring indicator.

In diagnostic loopback the external lines are ignored, and each level is taken from one of the port's own modem-control outputs. Edge detection works on the value after this selection. Switching loopback on or off therefore raises the same flags that a real line change would.

A read strobe returns the current byte and clears all four flags in the same cycle. An event that lands in the cycle of a read survives the clear. The interrupt request is a level formed from the flags and the enable. While automatic flow control is active, the clear-to-send flag is left out of it.

Top module: `modem_status_tracker`

## Requirements
- R1: During and right after a synchronous reset with all lines inactive (high) and loopback off, the status byte reads 0x00 and the interrupt is low.
- R2: With loopback off, status bits 7, 6, 5 and 4 show the inverted carrier detect, ring indicator, data set ready and clear to send lines. A line change appears in the byte after two rising clock edges.
- R3: With loopback on, bit 7 follows control bit 3, bit 6 follows control bit 2, bit 5 follows control bit 0 and bit 4 follows control bit 1 of the 4-bit modem-control input, at once. The external lines have no effect on the byte.
- R4: Bits 3, 1 and 0 are set one clock after the effective carrier detect, data set ready or clear to send level changes in either direction.
- R5: Bit 2 is set one clock after the effective ring level falls from 1 to 0 (the active-low line returns high). A rise of that level does not set it.
- R6: The delta flags stay set until a read. During the read strobe the byte shows the flags, and they read zero from the next cycle unless a new event arrives.
- R7: A delta event in the same cycle as a read leaves its flag set after the read.
- R8: The interrupt is high exactly while it is enabled and any of bits 3..0 is set. It stays high over idle cycles and drops at once when the enable is removed.
- R9: While automatic flow control is enabled, bit 0 alone does not raise the interrupt. Bits 3..1 still do.
- R10: Switching loopback on or off sets the delta flags for every effective level that the switch changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cd_n | input | 1 | Carrier detect line, active low, asynchronous |
| ri_n | input | 1 | Ring indicator line, active low, asynchronous |
| dsr_n | input | 1 | Data set ready line, active low, asynchronous |
| cts_n | input | 1 | Clear to send line, active low, asynchronous |
| loop_en | input | 1 | Diagnostic loopback select |
| mctl | input | 4 | Modem-control outputs: [0] DTR, [1] RTS, [2] OUT1, [3] OUT2 |
| flow_auto | input | 1 | Automatic flow control active |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | One-cycle read strobe for the status byte |
| status | output | 8 | Status byte: levels in [7:4], flags in [3:0] |
| irq | output | 1 | Modem-status interrupt request, level |

## Verification
Two things can land in the same clock cycle: the flag clear caused by a read, and a new edge on an effective line. The bench provokes this in loopback. It first raises two flags. Then, in the cycle that carries the read strobe, it toggles the request-to-send control bit. The flags for the old events must be gone after that edge, and the flag for the new edge must be present. The byte sampled during the strobe must also show the pre-clear flags.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int unsigned MC_DTR  = 0;
    localparam int unsigned MC_RTS  = 1;
    localparam int unsigned MC_OUT1 = 2;
    localparam int unsigned MC_OUT2 = 3;
    localparam int unsigned MC_W    = 4;

    // positive "asserted" level of each handshake line
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;

    // sticky event flags, same bit order as the status nibble
    typedef struct packed {
        logic dcd;
        logic teri;
        logic ddsr;
        logic dcts;
    } mdelta_t;

    localparam int unsigned LINE_W = $bits(mline_t);

    function automatic mline_t loop_map(input logic [MC_W-1:0] mc);
        mline_t l;
        l.cd  = mc[MC_OUT2];
        l.ri  = mc[MC_OUT1];
        l.dsr = mc[MC_DTR];
        l.cts = mc[MC_RTS];
        return l;
    endfunction

    function automatic mline_t invert_lines(input logic [LINE_W-1:0] raw_n);
        return mline_t'(~raw_n);
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= {WIDTH{RESET_VAL}};
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/msr_line_mux.sv
module msr_line_mux
    import msr_pkg::*;
(
    input  logic [LINE_W-1:0] raw_n,
    input  logic              loop_en,
    input  logic [MC_W-1:0]   mctl,
    output mline_t            eff
);
    always_comb begin
        if (loop_en)
            eff = loop_map(mctl);
        else
            eff = invert_lines(raw_n);
    end
endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mline_t  cur,
    input  logic    rd_stb,
    output mdelta_t flags
);
    mline_t  prev_q;
    mdelta_t flags_q;
    mdelta_t hit;

    always_comb begin
        hit.dcd  = cur.cd  ^ prev_q.cd;
        hit.ddsr = cur.dsr ^ prev_q.dsr;
        hit.dcts = cur.cts ^ prev_q.cts;
        hit.teri = prev_q.ri & ~cur.ri;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            flags_q <= '0;
        end else begin
            prev_q  <= cur;
            flags_q <= (rd_stb ? mdelta_t'('0) : flags_q) | hit;
        end
    end

    assign flags = flags_q;

    assert_dsr_change_R4: assert property (@(posedge clk) disable iff (rst)
        (cur.dsr != prev_q.dsr) |=> flags_q.ddsr);
    assert_cd_change_R4: assert property (@(posedge clk) disable iff (rst)
        (cur.cd != prev_q.cd) |=> flags_q.dcd);
    assert_ring_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (prev_q.ri && !cur.ri) |=> flags_q.teri);
    assert_ring_nofall_R5: assert property (@(posedge clk) disable iff (rst)
        (!flags_q.teri && !(prev_q.ri && !cur.ri)) |=> !flags_q.teri);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && cur == prev_q) |=> (flags_q == '0));
    assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && cur.cts != prev_q.cts) |=> flags_q.dcts);
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
    import msr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cd_n,
    input  logic            ri_n,
    input  logic            dsr_n,
    input  logic            cts_n,
    input  logic            loop_en,
    input  logic [MC_W-1:0] mctl,
    input  logic            flow_auto,
    input  logic            irq_en,
    input  logic            rd_stb,
    output logic [7:0]      status,
    output logic            irq
);
    logic [LINE_W-1:0] raw_sync_n;
    mline_t            eff;
    mdelta_t           flags;
    logic              irq_src;

    msr_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cd_n, ri_n, dsr_n, cts_n}),
        .q   (raw_sync_n)
    );

    msr_line_mux u_mux (
        .raw_n   (raw_sync_n),
        .loop_en (loop_en),
        .mctl    (mctl),
        .eff     (eff)
    );

    msr_delta u_delta (
        .clk    (clk),
        .rst    (rst),
        .cur    (eff),
        .rd_stb (rd_stb),
        .flags  (flags)
    );

    always_comb begin
        irq_src = flags.dcd | flags.teri | flags.ddsr | (flags.dcts & ~flow_auto);
    end

    assign status = {eff, flags};
    assign irq    = irq_en & irq_src;

    assert_loop_map_R3: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (status[7:4] == {mctl[3], mctl[2], mctl[0], mctl[1]}));
    assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);
    assert_irq_on_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_en && status[3:1] != 3'b000) |-> irq);
    assert_flow_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (flow_auto && status[3:1] == 3'b000) |-> !irq);
endmodule

// File: tb/modem_status_tracker_test.sv
module modem_status_tracker_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       cd_n, ri_n, dsr_n, cts_n;
    logic       loop_en;
    logic [3:0] mctl;
    logic       flow_auto, irq_en, rd_stb;
    logic [7:0] status;
    logic       irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    modem_status_tracker uut (
        .clk(clk), .rst(rst), .cd_n(cd_n), .ri_n(ri_n), .dsr_n(dsr_n), .cts_n(cts_n),
        .loop_en(loop_en), .mctl(mctl), .flow_auto(flow_auto), .irq_en(irq_en),
        .rd_stb(rd_stb), .status(status), .irq(irq)
    );

    // {loop, mctl[3:0], lines_n{cd,ri,dsr,cts}, irq_en, flow, read, exp_status, exp_irq}
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'h0, 4'hF, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0},
        {1'b0, 4'h0, 4'h7, 1'b1, 1'b0, 1'b1, 8'h88, 1'b1},
        {1'b0, 4'h0, 4'h6, 1'b1, 1'b0, 1'b0, 8'h91, 1'b1},
        {1'b0, 4'h0, 4'h6, 1'b1, 1'b1, 1'b0, 8'h91, 1'b0},
        {1'b0, 4'h0, 4'h4, 1'b1, 1'b1, 1'b1, 8'hB3, 1'b1},
        {1'b0, 4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 8'hF0, 1'b0},
        {1'b0, 4'h0, 4'h4, 1'b1, 1'b0, 1'b1, 8'hB4, 1'b1},
        {1'b0, 4'h0, 4'hF, 1'b0, 1'b0, 1'b1, 8'h0B, 1'b0},
        {1'b1, 4'h0, 4'hF, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b1, 4'h1, 4'hF, 1'b1, 1'b0, 1'b1, 8'h22, 1'b1},
        {1'b1, 4'h2, 4'hF, 1'b1, 1'b0, 1'b1, 8'h13, 1'b1},
        {1'b1, 4'hC, 4'hF, 1'b1, 1'b0, 1'b0, 8'hC9, 1'b1},
        {1'b1, 4'h8, 4'hF, 1'b1, 1'b0, 1'b1, 8'h8D, 1'b1},
        {1'b0, 4'h8, 4'hF, 1'b1, 1'b0, 1'b1, 8'h08, 1'b1},
        {1'b1, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
        {1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 8'hFB, 1'b1},
        {1'b0, 4'h0, 4'hF, 1'b1, 1'b0, 1'b1, 8'h0F, 1'b1}
    };

    function automatic string vec_req(input int i);
        case (i)
            0:       return "R1";
            1, 2:    return "R2/R4";
            3, 4:    return "R9";
            5, 6:    return "R5";
            7:       return "R8";
            8, 9, 10, 11: return "R3";
            12:      return "R5/R3";
            13, 15:  return "R10";
            14:      return "R3/R10";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s status/irq act=%h exp=%h", req, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; {cd_n, ri_n, dsr_n, cts_n} = 4'hF; loop_en = 1'b0; mctl = 4'h0;
        flow_auto = 1'b0; irq_en = 1'b1; rd_stb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {status, irq}, {8'h00, 1'b0});
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 after reset", {status, irq}, {8'h00, 1'b0});

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            loop_en = v[20]; mctl = v[19:16]; {cd_n, ri_n, dsr_n, cts_n} = v[15:12];
            irq_en = v[11]; flow_auto = v[10];
            repeat (4) @(negedge clk);
            chk(vec_req(i), {status, irq}, v[8:0]);
            if (v[9]) begin
                rd_stb = 1'b1;
                #1;
                chk("R6 read value", {status, irq}, v[8:0]);
                @(negedge clk);
                rd_stb = 1'b0;
            end
        end

        // R4 / R2 latency of a real line change
        cts_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R2 level after two edges", {status, irq}, {8'h10, 1'b0});
        @(negedge clk);
        chk("R4 flag one edge later", {status, irq}, {8'h11, 1'b1});
        repeat (3) @(negedge clk);
        chk("R8 level held", {status, irq}, {8'h11, 1'b1});
        irq_en = 1'b0;
        #1;
        chk("R8 enable removed", {status, irq}, {8'h11, 1'b0});
        irq_en = 1'b1;
        @(negedge clk);
        rd_stb = 1'b1;
        #1;
        chk("R6 read shows flag", {status, irq}, {8'h11, 1'b1});
        @(negedge clk);
        rd_stb = 1'b0;
        #1;
        chk("R6 cleared after read", {status, irq}, {8'h10, 1'b0});
        repeat (2) @(negedge clk);
        chk("R6 stays clear", {status, irq}, {8'h10, 1'b0});

        // R7 read colliding with a new edge (loopback)
        loop_en = 1'b1; mctl = 4'h1;
        @(negedge clk);
        chk("R10 loop switch flags", {status, irq}, {8'h23, 1'b1});
        rd_stb = 1'b1; mctl = 4'h3;
        #1;
        chk("R7 byte during read", {status, irq}, {8'h33, 1'b1});
        @(negedge clk);
        rd_stb = 1'b0;
        #1;
        chk("R7 new edge survives read", {status, irq}, {8'h31, 1'b1});
        flow_auto = 1'b1;
        #1;
        chk("R9 cts flag masked", {status, irq}, {8'h31, 1'b0});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule